// File: doc/BRIEF.md
# Multiplexed-Bus Register and RAM Window

This block places a 128-location byte space behind a host bus that shares one set of lines between address and data. A positive address strobe marks the address phase, and its falling edge captures the location. Active-low read, write and chip-select strobes then carry the data phase. The bus is split at the block edge into an input byte, an output byte and an output-enable, and a pad ring recombines them into an open bidirectional bus. A power-good input and a host reset input can both shut out the host.

The first ten locations hold the time, calendar and alarm bytes. The next four are control and status registers. The remaining 114 are general storage. The timekeeping core is outside this block. It writes the time bytes through a side port, reads them and the two writable control registers through flat outputs, and supplies the contents of the two status registers. The core learns that the host has read the first status register from a one-cycle pulse. A RAM-clear request fills the storage area with ones and leaves the clock bytes alone.

All strobes are sampled on the system clock. The parameter `SYNC_STAGES` can add synchronizer flops in front of the edge detectors.

Top module: `mbus_regfile_if`

## Requirements
- R1: While `rst_n` is low, `bus_oe` and `rd_c_pulse` are 0. After reset, every time byte, `ctrl_a_o`, `ctrl_b_o` and every storage byte read back 0.
- R2: One clock after `as_i` is seen falling, the location is taken from `bus_in[6:0]`. `bus_in[7]` has no effect. A capture also happens when `cs_n` is high.
- R3: A write commits the `bus_in` byte present in the cycle where `wr_n` is seen rising. The new value is visible on the outputs one clock later.
- R4: `bus_out` shows the byte at the captured location whenever `bus_oe` is 1. `bus_oe` is 1 exactly while `rd_n`, `cs_n` are low and `rst_n`, `pwr_good`, `host_rst_n` are high.
- R5: A write commits only if `cs_n` stays low from the cycle `wr_n` falls through the cycle it rises. A read with `cs_n` high leaves `bus_oe` at 0.
- R6: While `pwr_good` is low or `host_rst_n` is low, no write commits and `bus_oe` stays 0.
- R7: Locations 0x00–0x09 map to bytes 0–9 of `clk_bytes_o`, with byte n at bits [8n+7:8n]. 0x0A is register A, 0x0B is register B (`ctrl_b_o`), 0x0C and 0x0D are status registers C and D, and 0x0E–0x7F are 114 storage bytes.
- R8: Registers C and D read `stat_c_in` and `stat_d_in`, and writes to them are dropped. Register A bit 7 reads `uip_in` and cannot be written. Bit 7 of location 0x00 keeps its value on a host write.
- R9: A cycle with `ram_clr` high sets all 114 storage bytes to 0xFF, even over a host write committing in that cycle. The time bytes are left unchanged.
- R10: `rd_c_pulse` is high for exactly one clock, one clock after `rd_n` is seen falling with access allowed and location 0x0C captured. Reads of other locations give no pulse.
- R11: `core_we` with `core_idx` below 10 writes `core_wdata` into that time byte, bit 7 of byte 0 included. If a host write to the same byte commits in the same cycle, the host write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| pwr_good | input | 1 | High when supply is valid; low blocks host access |
| host_rst_n | input | 1 | Active-low host reset; low blocks host access |
| as_i | input | 1 | Address strobe, location captured on falling edge |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, commit on rising edge |
| cs_n | input | 1 | Active-low chip select |
| bus_in | input | 8 | Shared bus value seen by the block |
| bus_out | output | 8 | Read data toward the bus |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| ram_clr | input | 1 | Fill storage bytes with ones |
| core_we | input | 1 | Core write enable for a time byte |
| core_idx | input | 4 | Time byte index for the core write |
| core_wdata | input | 8 | Core write data |
| uip_in | input | 1 | Value read as register A bit 7 |
| stat_c_in | input | 8 | Contents of status register C |
| stat_d_in | input | 8 | Contents of status register D |
| clk_bytes_o | output | 80 | Ten time bytes, byte n at bits [8n+7:8n] |
| ctrl_a_o | output | 7 | Writable bits 6:0 of register A |
| ctrl_b_o | output | 8 | Register B |
| rd_c_pulse | output | 1 | One-clock pulse on a host read of register C |

## Verification
Several corner cases are aimed at directly:
- Chip select dropped for one cycle in the middle of a write pulse. A design that looks at select only at the rising edge would commit the byte there.
- Addresses with bit 7 set. A design that decodes eight address bits would miss the storage byte and read zero.
- A RAM clear, and separately a core update, landing in the same cycle as a host commit. These expose the wrong priority as a stray data byte in the storage area or a lost host byte in the time area.
- The two read-only register A and seconds bits, which a careless store would overwrite.
- A status-C read, checked for a pulse that lasts exactly one cycle. A level instead of a pulse, or a pulse on another register, shows up here.

// File: rtl/mbus_rf_pkg.sv
package mbus_rf_pkg;

   // Region of the byte space selected by the captured location
   typedef enum logic [2:0] {
      RGN_TIME = 3'd0,
      RGN_CTLA = 3'd1,
      RGN_CTLB = 3'd2,
      RGN_STC  = 3'd3,
      RGN_STD  = 3'd4,
      RGN_USER = 3'd5
   } rgn_e;

   // Number of control/status locations between time bytes and storage
   localparam int unsigned CTRL_SLOTS = 4;

endpackage

// File: rtl/mbus_rf_sync.sv
module mbus_rf_sync #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] prev
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg[s] <= RST_VAL;
                  else        stg[s] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg[s] <= RST_VAL;
                  else        stg[s] <= stg[s-1];
               end
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

   // One-cycle delayed copy for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= q;
   end

endmodule

// File: rtl/mbus_rf_decode.sv
module mbus_rf_decode
   import mbus_rf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned CLK_BYTES = 10,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned RAM_IDX_W = 7
) (
   input  logic [ADDR_W-1:0]    addr,
   output rgn_e                 rgn,
   output logic [IDX_W-1:0]     clk_idx,
   output logic [RAM_IDX_W-1:0] ram_idx
);

   localparam int unsigned CTRL_BASE = CLK_BYTES;
   localparam int unsigned RAM_BASE  = CLK_BYTES + CTRL_SLOTS;

   logic [ADDR_W-1:0] ram_off;

   always_comb begin
      if (addr < ADDR_W'(CLK_BYTES))            rgn = RGN_TIME;
      else if (addr == ADDR_W'(CTRL_BASE))      rgn = RGN_CTLA;
      else if (addr == ADDR_W'(CTRL_BASE + 1))  rgn = RGN_CTLB;
      else if (addr == ADDR_W'(CTRL_BASE + 2))  rgn = RGN_STC;
      else if (addr == ADDR_W'(CTRL_BASE + 3))  rgn = RGN_STD;
      else                                      rgn = RGN_USER;
   end

   assign clk_idx = addr[IDX_W-1:0];
   assign ram_off = addr - ADDR_W'(RAM_BASE);
   assign ram_idx = ram_off[RAM_IDX_W-1:0];

endmodule

// File: rtl/mbus_rf_store.sv
module mbus_rf_store
   import mbus_rf_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CLK_BYTES   = 10,
   parameter int unsigned RAM_DEPTH   = 114,
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned RAM_IDX_W   = 7,
   parameter bit          SECS_MSB_RO = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_we,
   input  rgn_e                        rgn,
   input  logic [IDX_W-1:0]            clk_idx,
   input  logic [RAM_IDX_W-1:0]        ram_idx,
   input  logic [DATA_W-1:0]           wdata,
   input  logic                        ram_clr,
   input  logic                        core_we,
   input  logic [IDX_W-1:0]            core_idx,
   input  logic [DATA_W-1:0]           core_wdata,
   input  logic                        uip_in,
   input  logic [DATA_W-1:0]           stat_c_in,
   input  logic [DATA_W-1:0]           stat_d_in,
   output logic [DATA_W-1:0]           rdata,
   output logic [CLK_BYTES*DATA_W-1:0] time_flat,
   output logic [DATA_W-2:0]           ctrl_a,
   output logic [DATA_W-1:0]           ctrl_b
);

   localparam int unsigned MSB = DATA_W - 1;

   logic [DATA_W-1:0] tbyte [CLK_BYTES];
   logic [DATA_W-1:0] ram   [RAM_DEPTH];
   logic              time_we;
   logic              user_we;

   assign time_we = bus_we && (rgn == RGN_TIME);
   assign user_we = bus_we && (rgn == RGN_USER);

   // Time, calendar and alarm bytes: host write wins over core update
   generate
      for (genvar g = 0; g < CLK_BYTES; g++) begin : g_time
         logic              bus_hit;
         logic              core_hit;
         logic [DATA_W-1:0] bus_val;

         assign bus_hit  = time_we && (clk_idx == IDX_W'(g));
         assign core_hit = core_we && (core_idx == IDX_W'(g));

         if (g == 0 && SECS_MSB_RO) begin : g_ro_msb
            assign bus_val = {tbyte[g][MSB], wdata[MSB-1:0]};
         end else begin : g_full
            assign bus_val = wdata;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        tbyte[g] <= '0;
            else if (bus_hit)  tbyte[g] <= bus_val;
            else if (core_hit) tbyte[g] <= core_wdata;
         end

         assign time_flat[g*DATA_W +: DATA_W] = tbyte[g];
      end
   endgenerate

   // Storage bytes: clear request has top priority
   generate
      for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ram
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ram[g] <= '0;
            else if (ram_clr)
               ram[g] <= '1;
            else if (user_we && (ram_idx == RAM_IDX_W'(g)))
               ram[g] <= wdata;
         end
      end
   endgenerate

   // Writable control registers; bit MSB of A is not stored
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_a <= '0;
         ctrl_b <= '0;
      end else if (bus_we) begin
         if (rgn == RGN_CTLA) ctrl_a <= wdata[MSB-1:0];
         if (rgn == RGN_CTLB) ctrl_b <= wdata;
      end
   end

   // Read multiplexer
   always_comb begin
      unique case (rgn)
         RGN_TIME: rdata = (clk_idx < IDX_W'(CLK_BYTES)) ? tbyte[clk_idx] : '0;
         RGN_CTLA: rdata = {uip_in, ctrl_a};
         RGN_CTLB: rdata = ctrl_b;
         RGN_STC:  rdata = stat_c_in;
         RGN_STD:  rdata = stat_d_in;
         default:  rdata = (ram_idx < RAM_IDX_W'(RAM_DEPTH)) ? ram[ram_idx] : '0;
      endcase
   end

endmodule

// File: rtl/mbus_regfile_if.sv
module mbus_regfile_if
   import mbus_rf_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CLK_BYTES   = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SECS_MSB_RO = 1'b1,
   localparam int unsigned IDX_W      = $clog2(CLK_BYTES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pwr_good,
   input  logic                        host_rst_n,
   input  logic                        as_i,
   input  logic                        rd_n,
   input  logic                        wr_n,
   input  logic                        cs_n,
   input  logic [DATA_W-1:0]           bus_in,
   output logic [DATA_W-1:0]           bus_out,
   output logic                        bus_oe,
   input  logic                        ram_clr,
   input  logic                        core_we,
   input  logic [IDX_W-1:0]            core_idx,
   input  logic [DATA_W-1:0]           core_wdata,
   input  logic                        uip_in,
   input  logic [DATA_W-1:0]           stat_c_in,
   input  logic [DATA_W-1:0]           stat_d_in,
   output logic [CLK_BYTES*DATA_W-1:0] clk_bytes_o,
   output logic [DATA_W-2:0]           ctrl_a_o,
   output logic [DATA_W-1:0]           ctrl_b_o,
   output logic                        rd_c_pulse
);

   localparam int unsigned SPACE     = 1 << ADDR_W;
   localparam int unsigned RAM_BASE  = CLK_BYTES + CTRL_SLOTS;
   localparam int unsigned RAM_DEPTH = SPACE - RAM_BASE;
   localparam int unsigned RAM_IDX_W = $clog2(RAM_DEPTH);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("ADDR_W must not exceed DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (RAM_BASE >= SPACE) begin : g_bad_space
         $error("address space too small for clock and control bytes");
      end
      if (CLK_BYTES < 2) begin : g_bad_clk
         $error("CLK_BYTES must be at least 2");
      end
   endgenerate

   // Strobe bit order: [3]=cs_n [2]=wr_n [1]=rd_n [0]=as_i
   localparam logic [3:0] STB_IDLE = 4'b1110;

   logic [3:0] stb_raw, stb_s, stb_p;
   logic       as_s, rd_s, cs_s;
   logic       as_fall, rd_fall, wr_fall, wr_rise;
   logic       en_s;
   logic [ADDR_W-1:0] addr_q;
   logic       armed_q;
   logic       bus_we;
   logic       rdc_q;

   rgn_e                 rgn;
   logic [IDX_W-1:0]     clk_idx;
   logic [RAM_IDX_W-1:0] ram_idx;

   assign stb_raw = {cs_n, wr_n, rd_n, as_i};

   mbus_rf_sync #(
      .WIDTH   (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (STB_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stb_raw),
      .q     (stb_s),
      .prev  (stb_p)
   );

   assign as_s    = stb_s[0];
   assign rd_s    = stb_s[1];
   assign cs_s    = stb_s[3];
   assign as_fall =  stb_p[0] & ~stb_s[0];
   assign rd_fall =  stb_p[1] & ~stb_s[1];
   assign wr_fall =  stb_p[2] & ~stb_s[2];
   assign wr_rise = ~stb_p[2] &  stb_s[2];

   // Host access allowed: selected, powered and not held in host reset
   assign en_s = ~cs_s & pwr_good & host_rst_n;

   // Location capture on address strobe fall (select not required)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (as_fall) addr_q <= bus_in[ADDR_W-1:0];
   end

   // Write stays armed only while select is held for the whole pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (!en_s)   armed_q <= 1'b0;
      else if (wr_fall) armed_q <= 1'b1;
      else if (wr_rise) armed_q <= 1'b0;
   end

   assign bus_we = wr_rise & armed_q & en_s;

   mbus_rf_decode #(
      .ADDR_W    (ADDR_W),
      .CLK_BYTES (CLK_BYTES),
      .IDX_W     (IDX_W),
      .RAM_IDX_W (RAM_IDX_W)
   ) u_dec (
      .addr    (addr_q),
      .rgn     (rgn),
      .clk_idx (clk_idx),
      .ram_idx (ram_idx)
   );

   mbus_rf_store #(
      .DATA_W      (DATA_W),
      .CLK_BYTES   (CLK_BYTES),
      .RAM_DEPTH   (RAM_DEPTH),
      .IDX_W       (IDX_W),
      .RAM_IDX_W   (RAM_IDX_W),
      .SECS_MSB_RO (SECS_MSB_RO)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .rgn        (rgn),
      .clk_idx    (clk_idx),
      .ram_idx    (ram_idx),
      .wdata      (bus_in),
      .ram_clr    (ram_clr),
      .core_we    (core_we),
      .core_idx   (core_idx),
      .core_wdata (core_wdata),
      .uip_in     (uip_in),
      .stat_c_in  (stat_c_in),
      .stat_d_in  (stat_d_in),
      .rdata      (bus_out),
      .time_flat  (clk_bytes_o),
      .ctrl_a     (ctrl_a_o),
      .ctrl_b     (ctrl_b_o)
   );

   // Status-C read notification
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdc_q <= 1'b0;
      else        rdc_q <= rd_fall & en_s & (rgn == RGN_STC);
   end
   assign rd_c_pulse = rdc_q;

   // Bus drive follows the raw strobes so it releases at once
   assign bus_oe = rst_n & ~rd_n & ~cs_n & pwr_good & host_rst_n;

endmodule

// File: rtl/mbus_regfile_if_chk.sv
module mbus_regfile_if_chk #(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CLK_BYTES = 10,
   parameter int unsigned RAM_BASE  = 14
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        pwr_good,
   input logic                        ram_clr,
   input logic                        core_we,
   input logic                        bus_oe,
   input logic [DATA_W-1:0]           bus_out,
   input logic [CLK_BYTES*DATA_W-1:0] clk_bytes_o,
   input logic                        rd_c_pulse,
   input logic [ADDR_W-1:0]           addr_q,
   input logic                        as_s,
   input logic                        rd_s
);

   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   // R2: the captured location moves only after a seen strobe fall
   a_r2_addr_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && (addr_q != $past(addr_q))) |-> ($past(as_s, 2) && !$past(as_s)));

   // R6: unpowered, nothing but the core may change the time bytes
   a_r6_time_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(pwr_good) && !$past(core_we) && !$past(ram_clr))
      |-> $stable(clk_bytes_o));

   // R9: right after a clear, a storage read shows all ones
   a_r9_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(ram_clr) && $stable(addr_q) &&
       (addr_q >= ADDR_W'(RAM_BASE)) && bus_oe)
      |-> (bus_out == '1));

   // R10: the status-C pulse lasts one clock
   a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_c_pulse |=> !rd_c_pulse);

   // R10: the pulse follows a read of location 0x0C
   a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && rd_c_pulse) |->
      (!$past(rd_s) && ($past(addr_q) == ADDR_W'(CLK_BYTES + 2))));

endmodule

bind mbus_regfile_if mbus_regfile_if_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CLK_BYTES (CLK_BYTES),
   .RAM_BASE  (RAM_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_good    (pwr_good),
   .ram_clr     (ram_clr),
   .core_we     (core_we),
   .bus_oe      (bus_oe),
   .bus_out     (bus_out),
   .clk_bytes_o (clk_bytes_o),
   .rd_c_pulse  (rd_c_pulse),
   .addr_q      (addr_q),
   .as_s        (as_s),
   .rd_s        (rd_s)
);

// File: tb/mbus_regfile_if_test.sv
module mbus_regfile_if_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_good = 1'b1;
   logic        host_rst_n = 1'b1;
   logic        as_i = 1'b0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        cs_n = 1'b0;
   logic [7:0]  bus_in = 8'h00;
   logic [7:0]  bus_out;
   logic        bus_oe;
   logic        ram_clr = 1'b0;
   logic        core_we = 1'b0;
   logic [3:0]  core_idx = 4'd0;
   logic [7:0]  core_wdata = 8'h00;
   logic        uip_in = 1'b0;
   logic [7:0]  stat_c_in = 8'h12;
   logic [7:0]  stat_d_in = 8'h80;
   logic [79:0] clk_bytes_o;
   logic [6:0]  ctrl_a_o;
   logic [7:0]  ctrl_b_o;
   logic        rd_c_pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbus_regfile_if #(.SYNC_STAGES(0)) uut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .host_rst_n(host_rst_n),
      .as_i(as_i), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .ram_clr(ram_clr), .core_we(core_we), .core_idx(core_idx),
      .core_wdata(core_wdata), .uip_in(uip_in), .stat_c_in(stat_c_in),
      .stat_d_in(stat_d_in), .clk_bytes_o(clk_bytes_o), .ctrl_a_o(ctrl_a_o),
      .ctrl_b_o(ctrl_b_o), .rd_c_pulse(rd_c_pulse)
   );

   task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int         m_mem [128];
   logic [6:0] m_addr;
   logic       m_as_p, m_rd_p, m_wr_p, m_armed, m_pulse;

   function automatic logic [7:0] m_read(input logic [6:0] a);
      if (a == 7'd10)      return {uip_in, m_mem[10][6:0]};
      else if (a == 7'd12) return stat_c_in;
      else if (a == 7'd13) return stat_d_in;
      else                 return m_mem[a][7:0];
   endfunction

   always @(posedge clk) begin
      logic       en, commit;
      logic [6:0] oa;
      logic [7:0] old0;
      logic [79:0] exp_bytes;
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) m_mem[i] = 0;
         m_addr = '0; m_as_p = 1'b0; m_rd_p = 1'b1; m_wr_p = 1'b1;
         m_armed = 1'b0; m_pulse = 1'b0;
      end else begin
         en     = !cs_n && pwr_good && host_rst_n;
         oa     = m_addr;
         old0   = m_mem[0][7:0];
         commit = !m_wr_p && wr_n && m_armed && en;
         if (core_we && core_idx < 4'd10) m_mem[core_idx] = int'(core_wdata);
         if (commit) begin
            if (oa == 7'd0)        m_mem[0]  = int'({old0[7], bus_in[6:0]});
            else if (oa == 7'd10)  m_mem[10] = int'(bus_in & 8'h7F);
            else if (oa == 7'd12 || oa == 7'd13) begin end
            else                   m_mem[oa] = int'(bus_in);
         end
         if (ram_clr) for (int i = 14; i < 128; i++) m_mem[i] = 255;
         m_pulse = m_rd_p && !rd_n && en && (oa == 7'd12);
         if (!en)                     m_armed = 1'b0;
         else if (m_wr_p && !wr_n)    m_armed = 1'b1;
         else if (!m_wr_p && wr_n)    m_armed = 1'b0;
         if (m_as_p && !as_i) m_addr = bus_in[6:0];
         m_as_p = as_i; m_rd_p = rd_n; m_wr_p = wr_n;
      end
      #2;
      for (int i = 0; i < 10; i++) exp_bytes[i*8 +: 8] = m_mem[i][7:0];
      chk("R4 bus_oe", 80'(bus_oe), 80'(rst_n && !rd_n && !cs_n && pwr_good && host_rst_n));
      if (bus_oe) chk("R4 bus_out", 80'(bus_out), 80'(m_read(m_addr)));
      chk("R10 rd_c_pulse", 80'(rd_c_pulse), 80'(m_pulse));
      chk("R7 clk_bytes_o", clk_bytes_o, exp_bytes);
      chk("R7 ctrl_a_o", 80'(ctrl_a_o), 80'(m_mem[10][6:0]));
      chk("R7 ctrl_b_o", 80'(ctrl_b_o), 80'(m_mem[11][7:0]));
   end

   // ---------------- stimulus tasks ----------------
   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d,
                         input bit cs_glitch, input bit with_core, input bit with_clr);
      @(negedge clk) as_i = 1'b1; bus_in = a;
      @(negedge clk) as_i = 1'b0;
      @(negedge clk) wr_n = 1'b0; bus_in = d;
      if (cs_glitch) begin
         @(negedge clk) cs_n = 1'b1;
         @(negedge clk) cs_n = 1'b0;
      end
      @(negedge clk) wr_n = 1'b1; core_we = with_core; ram_clr = with_clr;
      @(negedge clk) core_we = 1'b0; ram_clr = 1'b0; bus_in = 8'h00;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [7:0] d,
                         output logic oe, output logic p1, output logic p2);
      @(negedge clk) as_i = 1'b1; bus_in = a;
      @(negedge clk) as_i = 1'b0;
      @(negedge clk) rd_n = 1'b0;
      @(posedge clk) #2; d = bus_out; oe = bus_oe; p1 = rd_c_pulse;
      @(posedge clk) #2; p2 = rd_c_pulse;
      @(negedge clk) rd_n = 1'b1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic oe, p1, p2;
      #1;
      rd_n = 1'b0;          // read request held during reset
      repeat (3) @(negedge clk);
      chk("R1 no drive in reset", 80'(bus_oe), 80'(0));
      chk("R1 no pulse in reset", 80'(rd_c_pulse), 80'(0));
      rd_n = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 time bytes zero", clk_bytes_o, 80'(0));
      bus_rd(8'h50, d, oe, p1, p2);
      chk("R1 storage zero", 80'(d), 80'(0));

      // R3 / R7: time byte write and readback
      bus_wr(8'h05, 8'h3C, 0, 0, 0);
      chk("R3 time byte 5 written", 80'(clk_bytes_o[47:40]), 80'h3C);
      bus_rd(8'h05, d, oe, p1, p2);
      chk("R4 read time byte 5", 80'(d), 80'h3C);
      chk("R4 drive while reading", 80'(oe), 80'(1));

      // R8: seconds bit 7 and register A bit 7
      bus_wr(8'h00, 8'hFF, 0, 0, 0);
      chk("R8 seconds msb kept", 80'(clk_bytes_o[7:0]), 80'h7F);
      bus_wr(8'h0A, 8'hFF, 0, 0, 0);
      chk("R8 ctrl A low bits", 80'(ctrl_a_o), 80'h7F);
      uip_in = 1'b0;
      bus_rd(8'h0A, d, oe, p1, p2);
      chk("R8 reg A msb from uip 0", 80'(d), 80'h7F);
      uip_in = 1'b1;
      bus_rd(8'h0A, d, oe, p1, p2);
      chk("R8 reg A msb from uip 1", 80'(d), 80'hFF);
      bus_wr(8'h0B, 8'hA6, 0, 0, 0);
      chk("R7 reg B", 80'(ctrl_b_o), 80'hA6);

      // R8 / R10: status C read-only and read pulse
      bus_wr(8'h0C, 8'h55, 0, 0, 0);
      bus_rd(8'h0C, d, oe, p1, p2);
      chk("R8 reg C reads input", 80'(d), 80'h12);
      chk("R10 pulse on C read", 80'(p1), 80'(1));
      chk("R10 pulse one cycle", 80'(p2), 80'(0));
      bus_wr(8'h0D, 8'h01, 0, 0, 0);
      bus_rd(8'h0D, d, oe, p1, p2);
      chk("R8 reg D reads input", 80'(d), 80'h80);
      chk("R10 no pulse on D read", 80'(p1), 80'(0));

      // R2 / R7: storage with address bit 7 set
      bus_wr(8'hC0, 8'hA5, 0, 0, 0);
      bus_rd(8'h40, d, oe, p1, p2);
      chk("R2 bit7 of address ignored", 80'(d), 80'hA5);
      bus_wr(8'h7F, 8'h3D, 0, 0, 0);
      bus_rd(8'h7F, d, oe, p1, p2);
      chk("R7 last storage byte", 80'(d), 80'h3D);
      bus_wr(8'h0E, 8'h4E, 0, 0, 0);
      bus_rd(8'h0E, d, oe, p1, p2);
      chk("R7 first storage byte", 80'(d), 80'h4E);

      // R5: chip select
      bus_wr(8'h41, 8'h11, 0, 0, 0);
      bus_wr(8'h41, 8'h22, 1, 0, 0);
      bus_rd(8'h41, d, oe, p1, p2);
      chk("R5 select drop mid-write", 80'(d), 80'h11);
      cs_n = 1'b1;
      bus_wr(8'h41, 8'h33, 0, 0, 0);
      bus_rd(8'h41, d, oe, p1, p2);
      chk("R5 no drive without select", 80'(oe), 80'(0));
      cs_n = 1'b0;
      bus_rd(8'h41, d, oe, p1, p2);
      chk("R5 unselected write dropped", 80'(d), 80'h11);
      chk("R2 address captured unselected", 80'(oe), 80'(1));

      // R6: power-good and host reset
      pwr_good = 1'b0;
      bus_wr(8'h05, 8'h99, 0, 0, 0);
      chk("R6 unpowered write dropped", 80'(clk_bytes_o[47:40]), 80'h3C);
      bus_rd(8'h05, d, oe, p1, p2);
      chk("R6 no drive unpowered", 80'(oe), 80'(0));
      pwr_good = 1'b1;
      host_rst_n = 1'b0;
      bus_wr(8'h41, 8'h77, 0, 0, 0);
      bus_rd(8'h0C, d, oe, p1, p2);
      chk("R6 no drive in host reset", 80'(oe), 80'(0));
      chk("R6 no pulse in host reset", 80'(p1), 80'(0));
      host_rst_n = 1'b1;
      bus_rd(8'h41, d, oe, p1, p2);
      chk("R6 host reset write dropped", 80'(d), 80'h11);

      // R11: core update and collision
      @(negedge clk) core_idx = 4'd3; core_wdata = 8'h21; core_we = 1'b1;
      @(negedge clk) core_we = 1'b0;
      chk("R11 core writes byte 3", 80'(clk_bytes_o[31:24]), 80'h21);
      @(negedge clk) core_idx = 4'd0; core_wdata = 8'h80; core_we = 1'b1;
      @(negedge clk) core_we = 1'b0;
      chk("R11 core sets seconds msb", 80'(clk_bytes_o[7:0]), 80'h80);
      core_idx = 4'd3; core_wdata = 8'hEE;
      bus_wr(8'h03, 8'h42, 0, 1, 0);
      chk("R11 host wins collision", 80'(clk_bytes_o[31:24]), 80'h42);

      // R9: RAM clear
      @(negedge clk) ram_clr = 1'b1;
      @(negedge clk) ram_clr = 1'b0;
      bus_rd(8'h40, d, oe, p1, p2);
      chk("R9 storage cleared", 80'(d), 80'hFF);
      chk("R9 time byte kept", 80'(clk_bytes_o[47:40]), 80'h3C);
      bus_wr(8'h20, 8'h5A, 0, 0, 1);
      bus_rd(8'h20, d, oe, p1, p2);
      chk("R9 clear beats write", 80'(d), 80'hFF);
      bus_wr(8'h20, 8'h5A, 0, 0, 0);
      bus_rd(8'h20, d, oe, p1, p2);
      chk("R3 write after clear", 80'(d), 80'h5A);

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule